// File: doc/BRIEF.md
# Low-Transition Scan Pattern Generator

This block feeds the serial input of a scan chain during built-in self-test with pseudorandom data that switches far less often than raw shift-register output. A 16-bit maximal-length linear feedback shift register advances once per shift cycle. Three of its cells are combined by an AND function. The result drives the toggle input of a single flip-flop, and that flip-flop's output is the bit presented to the chain. The AND of three roughly balanced bits is 1 on about one shift in eight, so the chain input holds its value most of the time. This lowers switching in the chain while stimulus is loaded. Switching while responses are unloaded is not affected.

Software or a test controller loads a seed, then holds the shift enable high while the chain is filled. A one-cycle strobe marks each completed chain load of a parameterised length, so the controller knows when to issue a capture cycle.

Top module: `ltpg_top`

## Requirements
- R1: After reset the register holds 0x0001, `scan_in_bit` is 0 and `pattern_done` is 0.
- R2: On each enabled shift the register moves one place toward the most significant bit. The new bit 0 is the XOR of bits 15, 13, 12 and 10 taken before the shift.
- R3: On an enabled shift, `scan_in_bit` inverts exactly when bits 0, 5 and 10 of the register were all 1 before that shift. Otherwise it keeps its value.
- R4: While `shift_en` is 0 and `seed_load` is 0, the register, `scan_in_bit` and the shift count all hold.
- R5: A cycle with `seed_load` high writes `seed_val` into the register, clears `scan_in_bit` and clears the shift count. This takes priority over `shift_en`.
- R6: A seed of zero is written as 0x0001.
- R7: `pattern_done` is high for exactly the one cycle after every CHAIN_LEN-th enabled shift counted since reset or the last seed load. Cycles without a shift do not advance the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| seed_load | input | 1 | Write seed, clear toggle bit and count |
| seed_val | input | 16 | Seed value |
| shift_en | input | 1 | Advance one shift this cycle |
| scan_in_bit | output | 1 | Serial data to the chain |
| pattern_done | output | 1 | One-cycle strobe after each full chain load |

## Verification
A corrupt register state first shows at `scan_in_bit`. The bit inverts on a shift where the reference says it must hold, or holds where it must invert. Because the gate pattern matches about once every eight shifts, such a divergence normally appears within a few tens of shifts. A count error appears as a `pattern_done` strobe that is missing or misplaced, at the latest CHAIN_LEN shifts later. A wrong seed path, including the zero-seed substitution, is exposed by the bit sequence that follows the load.

// File: rtl/ltpg_pkg.sv
// Shared defaults for the low-transition scan pattern generator.
// Assumes a 16-bit register; the tap and gate masks are bit masks over it.
package ltpg_pkg;
    localparam int          LFSR_W_DEF    = 16;
    localparam logic [15:0] TAP_MASK_DEF  = 16'hB400; // cells 15,13,12,10
    localparam logic [15:0] GATE_MASK_DEF = 16'h0421; // cells 10,5,0
    localparam logic [15:0] SEED_DEF      = 16'h0001;
    localparam int          CHAIN_LEN_DEF = 64;
endpackage

// File: rtl/ltpg_lfsr.sv
// Fibonacci shift register: shifts toward the MSB and inserts the XOR of the
// tapped cells at bit 0. Assumes TAP_MASK gives a maximal-length sequence.
// A load replaces a zero seed by 1 so the register never locks up.
module ltpg_lfsr #(
    parameter int             W          = 16,
    parameter logic [W-1:0]   TAP_MASK   = 16'hB400,
    parameter logic [W-1:0]   RESET_SEED = 16'h0001
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] seed,
    input  logic         step,
    output logic [W-1:0] state
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic         feedback;
    logic [W-1:0] seed_fixed;

    // Feedback bit and lock-up-free seed.
    always_comb begin
        feedback   = ^(state & TAP_MASK);
        seed_fixed = (seed == '0) ? ONE : seed;
    end

    // Register update: load wins over step.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= RESET_SEED;
        else if (load)
            state <= seed_fixed;
        else if (step)
            state <= {state[W-2:0], feedback};
    end
endmodule

// File: rtl/ltpg_toggle_cell.sv
// AND gate over the cells selected by GATE_MASK, feeding a toggle flip-flop.
// Assumes GATE_MASK is non-zero; the flip-flop inverts only on a step whose
// pre-step register value has every selected cell set.
module ltpg_toggle_cell #(
    parameter int           W         = 16,
    parameter logic [W-1:0] GATE_MASK = 16'h0421
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         step,
    input  logic [W-1:0] state,
    output logic         bit_q
);
    logic gate;

    // All selected cells high.
    always_comb gate = ((state & GATE_MASK) == GATE_MASK);

    // Toggle flip-flop with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bit_q <= 1'b0;
        else if (clear)
            bit_q <= 1'b0;
        else if (step && gate)
            bit_q <= ~bit_q;
    end
endmodule

// File: rtl/ltpg_pattern_count.sv
// Counts shifts and raises done for one cycle after every CHAIN_LEN-th shift.
// Assumes CHAIN_LEN >= 1; clear restarts the count from zero.
module ltpg_pattern_count #(
    parameter int CHAIN_LEN = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    output logic done
);
    localparam int CNT_W = (CHAIN_LEN > 1) ? $clog2(CHAIN_LEN) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CHAIN_LEN - 1);

    generate
        if (CHAIN_LEN == 1) begin : g_every
            // Every shift completes a pattern.
            always_ff @(posedge clk) begin
                if (!rst_n) done <= 1'b0;
                else        done <= step && !clear;
            end
        end else begin : g_count
            logic [CNT_W-1:0] cnt;
            // Shift counter with wrap and one-cycle strobe.
            always_ff @(posedge clk) begin
                if (!rst_n || clear) begin
                    cnt  <= '0;
                    done <= 1'b0;
                end else if (step) begin
                    cnt  <= (cnt == LAST) ? '0 : cnt + 1'b1;
                    done <= (cnt == LAST);
                end else begin
                    done <= 1'b0;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/ltpg_top.sv
// Low-transition scan-in generator: register, gated toggle bit and pattern
// counter. A seed load takes priority over shift enable in the same cycle.
module ltpg_top
    import ltpg_pkg::*;
#(
    parameter int                  LFSR_W    = LFSR_W_DEF,
    parameter logic [LFSR_W-1:0]   TAP_MASK  = TAP_MASK_DEF,
    parameter logic [LFSR_W-1:0]   GATE_MASK = GATE_MASK_DEF,
    parameter logic [LFSR_W-1:0]   RST_SEED  = SEED_DEF,
    parameter int                  CHAIN_LEN = CHAIN_LEN_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seed_load,
    input  logic [LFSR_W-1:0] seed_val,
    input  logic              shift_en,
    output logic              scan_in_bit,
    output logic              pattern_done
);
    logic              shift_step;
    logic [LFSR_W-1:0] lfsr_q;

    // A shift only happens when no seed load is pending.
    always_comb shift_step = shift_en && !seed_load;

    ltpg_lfsr #(.W(LFSR_W), .TAP_MASK(TAP_MASK), .RESET_SEED(RST_SEED)) u_lfsr (
        .clk(clk), .rst_n(rst_n), .load(seed_load), .seed(seed_val),
        .step(shift_step), .state(lfsr_q)
    );

    ltpg_toggle_cell #(.W(LFSR_W), .GATE_MASK(GATE_MASK)) u_tff (
        .clk(clk), .rst_n(rst_n), .clear(seed_load), .step(shift_step),
        .state(lfsr_q), .bit_q(scan_in_bit)
    );

    ltpg_pattern_count #(.CHAIN_LEN(CHAIN_LEN)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clear(seed_load), .step(shift_step),
        .done(pattern_done)
    );
endmodule

// File: rtl/ltpg_checker.sv
// Property checks for ltpg_top, bound into every instance.
module ltpg_checker #(
    parameter int              W         = 16,
    parameter logic [W-1:0]    GATE_MASK = 16'h0421,
    parameter int              CHAIN_LEN = 64
) (
    input logic         clk,
    input logic         rst_n,
    input logic         seed_load,
    input logic [W-1:0] seed_val,
    input logic         shift_en,
    input logic         scan_in_bit,
    input logic         pattern_done,
    input logic [W-1:0] lfsr_q
);
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_en && !seed_load) |=> ($stable(scan_in_bit) && $stable(lfsr_q) && !pattern_done)); // R4
    AST_SEED_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        seed_load |=> (!scan_in_bit && !pattern_done)); // R5
    AST_ZERO_SEED: assert property (@(posedge clk) disable iff (!rst_n)
        (seed_load && seed_val == '0) |=> (lfsr_q == W'(1))); // R6
    AST_GATED_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !seed_load && ((lfsr_q & GATE_MASK) != GATE_MASK)) |=> $stable(scan_in_bit)); // R3
    AST_NO_LOCKUP: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != '0); // R2
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (pattern_done && CHAIN_LEN > 1) |=> !pattern_done); // R7
endmodule

bind ltpg_top ltpg_checker #(.W(LFSR_W), .GATE_MASK(GATE_MASK), .CHAIN_LEN(CHAIN_LEN)) u_chk (
    .clk(clk), .rst_n(rst_n), .seed_load(seed_load), .seed_val(seed_val),
    .shift_en(shift_en), .scan_in_bit(scan_in_bit), .pattern_done(pattern_done),
    .lfsr_q(lfsr_q)
);

// File: tb/tb_ltpg_top.sv
`timescale 1ns/1ps
module tb_ltpg_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        seed_load = 1'b0;
    logic [15:0] seed_val = '0;
    logic        shift_en = 1'b0;
    logic        scan_in_bit;
    logic        pattern_done;

    int tests = 0;
    int fails = 0;
    bit finished = 0;
    string g_tag = "";
    int toggles = 0;
    int shifts = 0;

    logic [15:0] m_lfsr;
    logic        m_scan;
    int          m_cnt;
    logic        m_done;

    always #4 clk = ~clk;

    ltpg_top dut (
        .clk(clk), .rst_n(rst_n), .seed_load(seed_load), .seed_val(seed_val),
        .shift_en(shift_en), .scan_in_bit(scan_in_bit), .pattern_done(pattern_done)
    );

    function automatic logic [15:0] f_next(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    function automatic logic f_gate(input logic [15:0] s);
        return s[0] & s[5] & s[10];
    endfunction

    task automatic check_bit(input string tag, input logic act, input logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    // One cycle: drive at negedge, update the reference, check at next negedge.
    task automatic step(input logic ld, input logic [15:0] sd, input logic en);
        logic  prev_scan;
        logic  gate_prev;
        string tag;
        seed_load = ld; seed_val = sd; shift_en = en;
        prev_scan = m_scan;
        gate_prev = f_gate(m_lfsr);
        if (ld) begin
            m_lfsr = (sd == 16'h0) ? 16'h0001 : sd;
            m_scan = 1'b0; m_cnt = 0; m_done = 1'b0;
        end else if (en) begin
            if (gate_prev) m_scan = ~m_scan;
            m_lfsr = f_next(m_lfsr);
            m_done = (m_cnt == 63);
            m_cnt  = (m_cnt == 63) ? 0 : m_cnt + 1;
            shifts++;
        end else begin
            m_done = 1'b0;
        end
        @(posedge clk);
        @(negedge clk);
        tag = ld ? "R5" : (en ? (g_tag != "" ? g_tag : "R3") : "R4");
        check_bit(tag, scan_in_bit, m_scan);
        check_bit("R7", pattern_done, m_done);
        if (!ld && en && scan_in_bit !== prev_scan) begin
            toggles++;
            tests++;
            if (!gate_prev) begin
                fails++;
                $display("FAIL R3: toggle with gate 0, actual %0b expected %0b", scan_in_bit, prev_scan);
            end
        end
    endtask

    initial begin
        #(8 * 200000);
        tests++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h1F2E3D4C));
        m_lfsr = 16'h0001; m_scan = 1'b0; m_cnt = 0; m_done = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check_bit("R1", scan_in_bit, 1'b0);
        check_bit("R1", pattern_done, 1'b0);
        // R1 / R2: sequence from the reset seed 0x0001
        g_tag = "R1";
        for (int i = 0; i < 150; i++) step(1'b0, 16'h0, 1'b1);
        // R4: idle cycles hold everything
        for (int i = 0; i < 10; i++) step(1'b0, 16'h0, 1'b0);
        // R6: zero seed behaves like 0x0001
        step(1'b1, 16'h0000, 1'b0);
        g_tag = "R6";
        for (int i = 0; i < 150; i++) step(1'b0, 16'h0, 1'b1);
        // R5: seed load with shift_en high; all-ones seed toggles on first shift
        step(1'b1, 16'hFFFF, 1'b1);
        g_tag = "R3";
        step(1'b0, 16'h0, 1'b1);
        check_bit("R3", scan_in_bit, 1'b1);
        // R7: exact strobe position after 64 shifts with gaps
        step(1'b1, 16'hACE1, 1'b0);
        g_tag = "R7";
        for (int i = 0; i < 200; i++) step(1'b0, 16'h0, (i % 3) != 1);
        // R2: random run with occasional reseed
        g_tag = "R2";
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = $urandom_range(0, 99);
            if (r == 0) step(1'b1, 16'($urandom), ($urandom_range(0, 1) == 1));
            else        step(1'b0, 16'h0, r < 85);
        end
        // R3: toggle activity well below one in four shifts
        tests++;
        if (toggles * 4 >= shifts) begin
            fails++;
            $display("FAIL R3: toggles %0d expected below %0d", toggles, shifts / 4);
        end
        finish_run();
    end
endmodule